// File: doc/BRIEF.md
# Two-Byte Serial Packet Transmitter

This block sends a 16-bit packet over a single serial data line, paired with a transmit clock line. Software first writes the two halves of the packet into two byte registers, each with its own write strobe. A write to the control word with its start bit set then begins transmission. The control word also carries an interrupt-enable bit. The packet is clocked out one bit per transmit tick. That tick is a one-cycle enable that a programmable divider derives from the system clock, so the whole block runs in one clock domain.

A 4-bit bit counter drives the transmission. While the counter's top bit is 0, the low-byte shifter feeds the serial line; while it is 1, the high-byte shifter does. Each byte goes out most significant bit first, in NRZ form. After the sixteenth bit the block becomes idle again and gives a single-cycle done pulse. If interrupts were enabled for that packet, it also raises an interrupt request. The request stays high until the next write to the control word.

Top module: `pkt_tx`

## Requirements
- R1: While reset is asserted, and after it is released, `busy`, `done`, `irq`, `ser_data` and `ser_clk` are all 0.
- R2: While idle, a cycle with `lo_wr` high loads `wr_data` into the low-byte register, and a cycle with `hi_wr` high loads `wr_data` into the high-byte register.
- R3: A `ctrl_wr` cycle with `ctrl_data[0]` = 1 (start bit) while idle makes `busy` go high on the next cycle. At that cycle the value of `tick_div` and `ctrl_data[1]` (interrupt enable) are captured.
- R4: Starting with the cycle after the start write, bit i of the sequence is held on `ser_data` for `tick_div`+1 cycles, where `tick_div` must be 1 or more. The sequence is the low byte, bit 7 down to bit 0, followed by the high byte, bit 7 down to bit 0.
- R5: While busy, `ser_clk` is 0 for the first floor((`tick_div`+1)/2) cycles of each bit period and 1 for the rest of it.
- R6: Exactly 16×(`tick_div`+1) cycles after `busy` rises, `busy` is 0 and `done` is 1, and `done` lasts one cycle.
- R7: At the end of a packet, `irq` becomes 1 if the captured interrupt-enable bit was 1, and stays 0 otherwise. Once set, `irq` holds until a `ctrl_wr` cycle clears it.
- R8: `lo_wr` and `hi_wr` have no effect while busy, so the packet in flight is unchanged.
- R9: While busy, a start write and any change of `tick_div` have no effect on the packet or its timing.
- R10: If a `ctrl_wr` cycle falls in the final cycle of a packet, ending the packet takes priority. `irq` takes the captured enable value, the start bit is ignored, and the block is idle afterwards.
- R11: While idle, `ser_data` and `ser_clk` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lo_wr | input | 1 | Load strobe for the low byte |
| hi_wr | input | 1 | Load strobe for the high byte |
| wr_data | input | 8 | Byte data for the two load strobes |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_data | input | 8 | Control word: bit 0 is start, bit 1 is interrupt enable |
| tick_div | input | DIV_W | Bit period minus one, in system clock cycles (1 or more) |
| ser_data | output | 1 | Serial NRZ data output |
| ser_clk | output | 1 | Transmit clock output |
| busy | output | 1 | High while a packet is being sent |
| done | output | 1 | One-cycle pulse at the end of a packet |
| irq | output | 1 | Interrupt request, held until the next control write |

## Verification
Two functions can fall in the same cycle here. One is the end-of-packet event, which sets `irq` and drops `busy`. The other is a control-word write, which clears `irq` and may try to start a new packet. The bench provokes this by issuing a start write exactly in the last system clock cycle of the sixteenth bit period. It judges the outcome at the next sampling point: `irq` must equal the enable bit captured for the finished packet, `done` must pulse, and `busy` must stay low one cycle later.

// File: rtl/tx_pkg.sv
package tx_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned PKT_BYTES = 2;
  localparam int unsigned PKT_BITS  = BYTE_W * PKT_BYTES;
  localparam int unsigned CNT_W     = $clog2(PKT_BITS);
  localparam int unsigned CTRL_START = 0;
  localparam int unsigned CTRL_IE    = 1;
endpackage

// File: rtl/tx_rst_sync.sv
module tx_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/tx_tick_gen.sv
module tx_tick_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] limit,
  output logic             tick,
  output logic             phase_hi
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W:0]   half;
  logic             at_end;

  assign at_end = (cnt_q == limit);
  assign half   = ({1'b0, limit} + (DIV_W+1)'(1)) >> 1;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)        cnt_d = '0;
    else if (at_end) cnt_d = '0;
    else             cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick     = run && at_end;
  assign phase_hi = run && ({1'b0, cnt_q} >= half);
endmodule

// File: rtl/tx_byte_shifter.sv
module tx_byte_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] q, d;

  always_comb begin
    d = q;
    if (load)       d = din;
    else if (shift) d = {q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  assign msb = q[W-1];
endmodule

// File: rtl/tx_ctrl.sv
module tx_ctrl
  import tx_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic [7:0]       ctrl_data,
  input  logic [DIV_W-1:0] div_in,
  input  logic             tick,
  output logic             active,
  output logic             sel_hi,
  output logic [DIV_W-1:0] div_q,
  output logic             done,
  output logic             irq
);
  logic             active_q, active_d;
  logic [CNT_W-1:0] bit_cnt_q, bit_cnt_d;
  logic             ie_q, ie_d;
  logic             irq_q, irq_d;
  logic             done_q, done_d;
  logic [DIV_W-1:0] div_d;
  logic             start_ok, last_bit;

  assign start_ok = ctrl_wr && ctrl_data[CTRL_START] && !active_q;
  assign last_bit = active_q && tick && (bit_cnt_q == '1);

  always_comb begin
    active_d  = active_q;
    bit_cnt_d = bit_cnt_q;
    ie_d      = ie_q;
    div_d     = div_q;
    irq_d     = irq_q;
    done_d    = last_bit;
    if (start_ok) begin
      active_d  = 1'b1;
      bit_cnt_d = '0;
      ie_d      = ctrl_data[CTRL_IE];
      div_d     = div_in;
    end else if (active_q && tick) begin
      if (last_bit) begin
        active_d  = 1'b0;
        bit_cnt_d = '0;
      end else begin
        bit_cnt_d = bit_cnt_q + CNT_W'(1);
      end
    end
    // packet end outranks a same-cycle control write
    if (last_bit)     irq_d = ie_q;
    else if (ctrl_wr) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      bit_cnt_q <= '0;
      ie_q      <= 1'b0;
      div_q     <= '0;
      irq_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      active_q  <= active_d;
      bit_cnt_q <= bit_cnt_d;
      ie_q      <= ie_d;
      div_q     <= div_d;
      irq_q     <= irq_d;
      done_q    <= done_d;
    end
  end

  assign active = active_q;
  assign sel_hi = bit_cnt_q[CNT_W-1];
  assign done   = done_q;
  assign irq    = irq_q;
endmodule

// File: rtl/pkt_tx.sv
module pkt_tx
  import tx_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lo_wr,
  input  logic             hi_wr,
  input  logic [7:0]       wr_data,
  input  logic             ctrl_wr,
  input  logic [7:0]       ctrl_data,
  input  logic [DIV_W-1:0] tick_div,
  output logic             ser_data,
  output logic             ser_clk,
  output logic             busy,
  output logic             done,
  output logic             irq
);
  logic                 srst_n;
  logic                 active, sel_hi, tick, phase_hi;
  logic [DIV_W-1:0]     div_q;
  logic [PKT_BYTES-1:0] ld, sh, msb;

  tx_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  tx_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rst_n(srst_n), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
    .div_in(tick_div), .tick(tick), .active(active), .sel_hi(sel_hi),
    .div_q(div_q), .done(done), .irq(irq)
  );

  tx_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(srst_n), .run(active), .limit(div_q),
    .tick(tick), .phase_hi(phase_hi)
  );

  assign ld[0] = lo_wr && !active;
  assign ld[1] = hi_wr && !active;
  assign sh[0] = tick && !sel_hi;
  assign sh[1] = tick && sel_hi;

  for (genvar g = 0; g < PKT_BYTES; g++) begin : g_byte
    tx_byte_shifter #(.W(BYTE_W)) u_sh (
      .clk(clk), .rst_n(srst_n), .load(ld[g]), .din(wr_data[BYTE_W-1:0]),
      .shift(sh[g]), .msb(msb[g])
    );
  end

  assign ser_data = active && (sel_hi ? msb[1] : msb[0]);
  assign ser_clk  = phase_hi;
  assign busy     = active;
endmodule

// File: rtl/pkt_tx_checker.sv
module pkt_tx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ctrl_wr,
  input logic [7:0] ctrl_data,
  input logic       ser_data,
  input logic       ser_clk,
  input logic       busy,
  input logic       done,
  input logic       irq
);
  a_r3_start_takes: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && ctrl_data[0] && !busy |=> busy);
  a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
  a_r7_irq_rises_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> done);
  a_r7_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !ctrl_wr && !busy |=> irq);
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ser_data && !ser_clk);
endmodule

bind pkt_tx pkt_tx_checker u_chk (
  .clk(clk), .rst_n(srst_n), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
  .ser_data(ser_data), .ser_clk(ser_clk), .busy(busy), .done(done), .irq(irq)
);

// File: tb/pkt_tx_test.sv
module pkt_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic lo_wr, hi_wr, ctrl_wr;
  logic [7:0] wr_data, ctrl_data;
  logic [DIV_W-1:0] tick_div;
  logic ser_data, ser_clk, busy, done, irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_tx #(.DIV_W(DIV_W)) uut (
    .clk(clk), .rst_n(rst_n), .lo_wr(lo_wr), .hi_wr(hi_wr), .wr_data(wr_data),
    .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data), .tick_div(tick_div),
    .ser_data(ser_data), .ser_clk(ser_clk), .busy(busy), .done(done), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_bit(input logic [7:0] lo, input logic [7:0] hi, input int idx);
    return (idx < 8) ? lo[7-idx] : hi[15-idx];
  endfunction

  function automatic bit exp_clk(input int k, input int d);
    return (k % (d+1)) >= ((d+1) >> 1);
  endfunction

  task automatic load_byte(input bit hi_sel, input logic [7:0] v);
    @(negedge clk);
    wr_data = v; lo_wr = !hi_sel; hi_wr = hi_sel;
    @(negedge clk);
    lo_wr = 0; hi_wr = 0;
  endtask

  task automatic ctrl_write(input logic [7:0] v);
    @(negedge clk);
    ctrl_data = v; ctrl_wr = 1;
    @(negedge clk);
    ctrl_wr = 0;
  endtask

  // mode 0: plain, 1: loads/start/divider change mid-packet, 2: ctrl write in final cycle
  task automatic send_pkt(input logic [7:0] lo, input logic [7:0] hi, input int d,
                          input bit ie, input int mode);
    int n = 16 * (d + 1);
    int bad_d = 0, bad_c = 0, bad_b = 0, bad_done = 0;
    load_byte(0, lo);
    load_byte(1, hi);
    tick_div = DIV_W'(d);
    @(negedge clk);
    ctrl_data = {6'b0, ie, 1'b1}; ctrl_wr = 1;
    @(negedge clk);
    ctrl_wr = 0;
    for (int k = 0; k <= n; k++) begin
      if (k > 0) @(negedge clk);
      if (k < n) begin
        if (ser_data !== exp_bit(lo, hi, k / (d+1))) bad_d++;
        if (ser_clk  !== exp_clk(k, d)) bad_c++;
        if (busy !== 1'b1) bad_b++;
        if (done !== 1'b0) bad_done++;
      end
      if (mode == 1 && k == 2) begin
        wr_data = ~lo; lo_wr = 1; hi_wr = 1;
        ctrl_data = 8'h01; ctrl_wr = 1; tick_div = DIV_W'(d + 4);
      end
      if (mode == 1 && k == 3) begin
        lo_wr = 0; hi_wr = 0; ctrl_wr = 0;
      end
      if (mode == 2 && k == n-1) begin ctrl_data = 8'h03; ctrl_wr = 1; end
      if (mode == 2 && k == n)   ctrl_wr = 0;
    end
    chk(bad_d == 0, (mode == 1) ? "R4/R8 serial bits" : "R4 serial bits", bad_d, 0);
    chk(bad_c == 0, "R5 transmit clock", bad_c, 0);
    chk(bad_b == 0 && bad_done == 0, (mode == 1) ? "R9 busy span" : "R3 busy span",
        bad_b + bad_done, 0);
    chk(done === 1'b1 && busy === 1'b0, "R6 end timing", {done, busy}, 2);
    chk(irq === ie, (mode == 2) ? "R10 irq at collision" : "R7 irq at end", irq, ie);
    @(negedge clk);
    chk(done === 1'b0, "R6 done pulse width", done, 0);
    chk(busy === 1'b0, (mode == 2) ? "R10 start ignored" : "R11 idle after end", busy, 0);
    chk(ser_data === 1'b0 && ser_clk === 1'b0, "R11 idle lines", {ser_data, ser_clk}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; lo_wr = 0; hi_wr = 0; ctrl_wr = 0; wr_data = 0; ctrl_data = 0;
    tick_div = DIV_W'(1);
    repeat (3) @(negedge clk);
    chk({busy, done, irq, ser_data, ser_clk} === 5'b0, "R1 in reset",
        {busy, done, irq, ser_data, ser_clk}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk({busy, done, irq, ser_data, ser_clk} === 5'b0, "R1 after reset",
        {busy, done, irq, ser_data, ser_clk}, 0);

    // R2, R4: directed patterns
    send_pkt(8'hA5, 8'h3C, 1, 1'b1, 0);
    // R7: irq held, then cleared by a control write
    repeat (5) @(negedge clk);
    chk(irq === 1'b1, "R7 irq held", irq, 1);
    ctrl_write(8'h00);
    chk(irq === 1'b0, "R7 irq cleared by ctrl write", irq, 0);
    send_pkt(8'h80, 8'h01, 2, 1'b0, 0);
    // R8, R9: loads, start and divider change while busy
    send_pkt(8'h5A, 8'hC3, 3, 1'b1, 1);
    // R10: control write in final cycle
    send_pkt(8'hFF, 8'h00, 1, 1'b1, 2);
    send_pkt(8'h0F, 8'hF0, 4, 1'b0, 2);

    for (int i = 0; i < 20; i++) begin
      send_pkt(8'($urandom), 8'($urandom), 1 + int'($urandom % 6),
               1'($urandom % 2), int'($urandom % 3));
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule